// File: doc/BRIEF.md
# SPI Slave Receive Deserializer with Leading-Byte Drop and Word Packing

This block is the receive half of an SPI peripheral running as a slave. It watches the serial clock, the data-in line and an active-low select line, all of which arrive with no fixed timing relation to the system clock. It brings them into the system clock domain and samples the data line on the edge picked by a two-bit timing mode. From the samples it builds bytes, shifting either least significant bit first or most significant bit first.

Each time select goes low, a new frame begins. A four-bit drop count says how many bytes at the start of the frame are thrown away. The bytes that are kept are written to a receive FIFO write port. In packed mode, four bytes go into one 32-bit word. In low-latency mode, each byte gets its own write. When select rises, a packed word that is only partly filled is written out with a count of its valid lanes. Any bits of a byte that was not finished are lost.

The configuration inputs are static. Set them before the enable goes high, and change them only while select is high.

Top module: `spi_rx_pack`

## Requirements
- R1: The timing mode sets the sampling edge of the serial clock. Mode 0 (idle low) and mode 3 (idle high) sample on the rising edge. Mode 1 (idle low) and mode 2 (idle high) sample on the falling edge.
- R2: When the bit-order input is 0, the first bit received becomes bit 0 of the byte. When it is 1, the first bit received becomes bit 7.
- R3: After each falling edge of select, the first N complete bytes of the frame produce no write, where N is the drop count.
- R4: A drop count of 15 acts as 14.
- R5: The drop count is reloaded on every falling edge of select, so each frame drops again.
- R6: In packed mode (byte-mode input 0), every four kept bytes make one write with a byte count of 4. The first kept byte is in bits 7:0 and later bytes fill bits 15:8, 23:16 and 31:24 in that order.
- R7: In byte mode (byte-mode input 1), every kept byte makes its own write. The byte is in bits 7:0, bits 31:8 are zero and the byte count is 1.
- R8: When select rises in packed mode with 1 to 3 lanes filled, one write is made with the byte count equal to the number of filled lanes and the unfilled lanes zero. When no lane is filled, no write is made.
- R9: Bits of an unfinished byte that are pending when select rises are discarded and are not carried into the next frame.
- R10: While the enable input is low, serial clock and select activity cause no writes.
- R11: While reset is asserted and right after it, the write strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_enable | input | 1 | Slave receive enable |
| cfg_mode | input | 2 | Timing mode 0 to 3 |
| cfg_msb_first | input | 1 | 1 = MSB first, 0 = LSB first |
| cfg_byte_mode | input | 1 | 1 = one write per byte, 0 = pack four bytes |
| cfg_drop | input | 4 | Leading bytes to drop per frame (15 acts as 14) |
| spi_sck | input | 1 | Serial clock, asynchronous |
| spi_mosi | input | 1 | Serial data in, asynchronous |
| spi_cs_n | input | 1 | Frame select, active low, asynchronous |
| fifo_wr | output | 1 | Write strobe, one cycle per write |
| fifo_wdata | output | 32 | Write data word |
| fifo_nbytes | output | 3 | Number of valid byte lanes, 1 to 4 |

## Verification
The hardest cases to reach from the ports are the ones where a frame ends in an unusual state. One is a frame that ends with a partly filled word. Another is a frame that ends while a byte is half shifted in. A third is a frame that is shorter than its drop count. The serial driver can end a frame after any number of whole bytes plus a few stray bits, so these states can be reached on purpose. The scoreboard then expects exactly one short word and no leftover bits in the next frame. The driver also sends frames one after another in every timing mode, which shows that the drop count is reloaded for each frame.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  localparam int BYTE_W   = 8;
  localparam int MAX_DROP = 14;

  typedef struct packed {
    logic open;
    logic close;
  } frame_ev_t;
endpackage

// File: rtl/spi_rx_sync.sv
module spi_rx_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rst_val,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= rst_val;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_rx_deser.sv
module spi_rx_deser
  import spi_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [1:0]        mode,
  input  logic              msb_first,
  input  logic              sck_s,
  input  logic              mosi_s,
  input  logic              csn_s,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_q,
  output frame_ev_t         ev
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic              sck_d, csn_d;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg, shnext;
  logic              on_rise, samp, cs_fall, cs_rise;

  assign on_rise = ~(mode[1] ^ mode[0]);
  assign samp    = en & ~csn_s & (on_rise ? (sck_s & ~sck_d) : (~sck_s & sck_d));
  assign cs_fall = en & csn_d & ~csn_s;
  assign cs_rise = en & ~csn_d & csn_s;
  assign shnext  = msb_first ? {shreg[BYTE_W-2:0], mosi_s} : {mosi_s, shreg[BYTE_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d    <= 1'b0;
      csn_d    <= 1'b1;
      bitcnt   <= '0;
      shreg    <= '0;
      byte_vld <= 1'b0;
      byte_q   <= '0;
      ev       <= '0;
    end else begin
      sck_d    <= sck_s;
      csn_d    <= csn_s;
      byte_vld <= 1'b0;
      ev.open  <= cs_fall;
      ev.close <= cs_rise;
      if (cs_fall || cs_rise) begin
        bitcnt <= '0;
      end else if (samp) begin
        shreg <= shnext;
        if (bitcnt == CNT_W'(BYTE_W-1)) begin
          bitcnt   <= '0;
          byte_vld <= 1'b1;
          byte_q   <= shnext;
        end else begin
          bitcnt <= bitcnt + 1'b1;
        end
      end
    end
  end

  AST_BITS_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (cs_fall || cs_rise) |=> (bitcnt == '0)); // R9
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!en && !byte_vld) |=> !ev.open && !ev.close); // R10
endmodule

// File: rtl/spi_rx_gate.sv
module spi_rx_gate
  import spi_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        drop,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_d,
  input  frame_ev_t         ev,
  output logic              keep_vld,
  output logic [BYTE_W-1:0] keep_byte,
  output logic              close_q
);
  logic [3:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left      <= '0;
      keep_vld  <= 1'b0;
      keep_byte <= '0;
      close_q   <= 1'b0;
    end else begin
      close_q  <= ev.close;
      keep_vld <= byte_vld && (left == '0) && !ev.open;
      if (byte_vld) keep_byte <= byte_d;
      if (ev.open)
        left <= (drop > 4'(MAX_DROP)) ? 4'(MAX_DROP) : drop;
      else if (byte_vld && left != '0)
        left <= left - 1'b1;
    end
  end

  AST_DROP_CAP: assert property (@(posedge clk) disable iff (rst)
    left <= 4'(MAX_DROP)); // R4
  AST_NO_KEEP_WHILE_DROPPING: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && left != '0) |=> !keep_vld); // R3
endmodule

// File: rtl/spi_rx_packer.sv
module spi_rx_packer
  import spi_rx_pkg::*;
#(
  parameter int LANES = 4,
  localparam int WORD_W = BYTE_W * LANES,
  localparam int FILL_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int CNT_W  = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_mode,
  input  logic              keep_vld,
  input  logic [BYTE_W-1:0] keep_byte,
  input  logic              close_q,
  output logic              wr,
  output logic [WORD_W-1:0] wdata,
  output logic [CNT_W-1:0]  nbytes
);
  logic [WORD_W-1:0] acc, acc_next;
  logic [FILL_W-1:0] fill;

  always_comb begin
    acc_next = acc;
    acc_next[fill*BYTE_W +: BYTE_W] = keep_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      fill   <= '0;
      wr     <= 1'b0;
      wdata  <= '0;
      nbytes <= '0;
    end else begin
      wr <= 1'b0;
      if (keep_vld) begin
        if (byte_mode) begin
          wr     <= 1'b1;
          wdata  <= WORD_W'(keep_byte);
          nbytes <= CNT_W'(1);
        end else if (fill == FILL_W'(LANES-1)) begin
          wr     <= 1'b1;
          wdata  <= acc_next;
          nbytes <= CNT_W'(LANES);
          acc    <= '0;
          fill   <= '0;
        end else begin
          acc  <= acc_next;
          fill <= fill + 1'b1;
        end
      end else if (close_q && fill != '0) begin
        wr     <= 1'b1;
        wdata  <= acc;
        nbytes <= CNT_W'(fill);
        acc    <= '0;
        fill   <= '0;
      end
    end
  end

  AST_NBYTES_RANGE: assert property (@(posedge clk) disable iff (rst)
    wr |-> (nbytes != '0 && nbytes <= CNT_W'(LANES))); // R8
  AST_BYTE_MODE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (wr && byte_mode) |-> (nbytes == CNT_W'(1) && wdata[WORD_W-1:BYTE_W] == '0)); // R7
  AST_CLOSE_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (close_q && !keep_vld) |=> (fill == '0)); // R8
endmodule

// File: rtl/spi_rx_pack.sv
module spi_rx_pack
  import spi_rx_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cfg_enable,
  input  logic [1:0]                      cfg_mode,
  input  logic                            cfg_msb_first,
  input  logic                            cfg_byte_mode,
  input  logic [3:0]                      cfg_drop,
  input  logic                            spi_sck,
  input  logic                            spi_mosi,
  input  logic                            spi_cs_n,
  output logic                            fifo_wr,
  output logic [BYTE_W*LANES-1:0]         fifo_wdata,
  output logic [$clog2(LANES+1)-1:0]      fifo_nbytes
);
  logic [2:0]        pins_s;
  logic              byte_vld, keep_vld, close_q;
  logic [BYTE_W-1:0] byte_q, keep_byte;
  frame_ev_t         ev;

  spi_rx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .rst_val(3'b100),
    .d({spi_cs_n, spi_mosi, spi_sck}), .q(pins_s)
  );

  spi_rx_deser u_deser (
    .clk(clk), .rst(rst), .en(cfg_enable), .mode(cfg_mode),
    .msb_first(cfg_msb_first), .sck_s(pins_s[0]), .mosi_s(pins_s[1]),
    .csn_s(pins_s[2]), .byte_vld(byte_vld), .byte_q(byte_q), .ev(ev)
  );

  spi_rx_gate u_gate (
    .clk(clk), .rst(rst), .drop(cfg_drop), .byte_vld(byte_vld),
    .byte_d(byte_q), .ev(ev), .keep_vld(keep_vld),
    .keep_byte(keep_byte), .close_q(close_q)
  );

  spi_rx_packer #(.LANES(LANES)) u_pack (
    .clk(clk), .rst(rst), .byte_mode(cfg_byte_mode), .keep_vld(keep_vld),
    .keep_byte(keep_byte), .close_q(close_q), .wr(fifo_wr),
    .wdata(fifo_wdata), .nbytes(fifo_nbytes)
  );
endmodule

// File: tb/spi_rx_pack_test.sv
module spi_rx_pack_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_enable = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic        cfg_msb_first = 1'b0;
  logic        cfg_byte_mode = 1'b0;
  logic [3:0]  cfg_drop = 4'd0;
  logic        spi_sck = 1'b0;
  logic        spi_mosi = 1'b0;
  logic        spi_cs_n = 1'b1;
  logic        fifo_wr;
  logic [31:0] fifo_wdata;
  logic [2:0]  fifo_nbytes;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] d;
    logic [2:0]  n;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [7:0] fb[32];

  always #2.5 clk = ~clk;

  spi_rx_pack uut (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_mode(cfg_mode),
    .cfg_msb_first(cfg_msb_first), .cfg_byte_mode(cfg_byte_mode),
    .cfg_drop(cfg_drop), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
    .fifo_nbytes(fifo_nbytes)
  );

  task automatic check(input bit ok, input string tag, input string got, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %s expected %s", tag, got, exp);
    end
  endtask

  // Monitor: pops the scoreboard on each write
  always @(negedge clk) begin
    if (!rst && fifo_wr) begin
      if (sb.size() == 0) begin
        check(1'b0, "R10/R3 spurious write",
              $sformatf("%h/%0d", fifo_wdata, fifo_nbytes), "none");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(fifo_wdata == e.d && fifo_nbytes == e.n, e.tag,
              $sformatf("%h/%0d", fifo_wdata, fifo_nbytes),
              $sformatf("%h/%0d", e.d, e.n));
      end
    end
  end

  task automatic half();
    repeat (5) @(posedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      logic bitv;
      bitv = cfg_msb_first ? b[7-i] : b[i];
      if (cfg_mode[0] == 1'b0) begin
        spi_mosi = bitv; half(); spi_sck = ~spi_sck; half(); spi_sck = ~spi_sck;
      end else begin
        spi_sck = ~spi_sck; spi_mosi = bitv; half(); spi_sck = ~spi_sck; half();
      end
    end
  endtask

  // Driver: sends a frame and pushes the expected writes
  task automatic frame(input int nb, input int stray, input string tag, input bit expect_out);
    int drop, kept, fill;
    logic [31:0] w;
    drop = (cfg_drop > 14) ? 14 : int'(cfg_drop);
    fill = 0; w = '0; kept = 0;
    if (expect_out) begin
      for (int i = drop; i < nb; i++) begin
        kept++;
        if (cfg_byte_mode) sb.push_back('{{24'd0, fb[i]}, 3'd1, tag});
        else begin
          w[fill*8 +: 8] = fb[i];
          fill++;
          if (fill == 4) begin sb.push_back('{w, 3'd4, tag}); fill = 0; w = '0; end
        end
      end
      if (fill != 0) sb.push_back('{w, 3'(fill), {tag, " R8 partial"}});
    end
    spi_sck = cfg_mode[1];
    repeat (6) @(posedge clk);
    spi_cs_n = 1'b0;
    repeat (6) @(posedge clk);
    for (int i = 0; i < nb; i++) send_bits(fb[i], 8);
    if (stray > 0) send_bits(8'hFF, stray);
    repeat (6) @(posedge clk);
    spi_cs_n = 1'b1;
    repeat (12) @(posedge clk);
    check(sb.size() == 0, {tag, " all writes seen"}, $sformatf("%0d left", sb.size()), "0 left");
    sb.delete();
  endtask

  task automatic cfg(input logic [1:0] m, input logic msb, input logic bm, input logic [3:0] d);
    cfg_mode = m; cfg_msb_first = msb; cfg_byte_mode = bm; cfg_drop = d;
    spi_sck = m[1];
    repeat (4) @(posedge clk);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) fb[i] = 8'(8'h3C + i * 37);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(fifo_wr == 1'b0, "R11 write low in reset", $sformatf("%b", fifo_wr), "0");
    rst = 1'b0;
    @(negedge clk);
    check(fifo_wr == 1'b0, "R11 write low after reset", $sformatf("%b", fifo_wr), "0");

    // Disabled: nothing written
    cfg(2'd0, 1'b0, 1'b1, 4'd0);
    frame(3, 0, "R10 disabled", 1'b0);
    cfg_enable = 1'b1;

    cfg(2'd0, 1'b0, 1'b0, 4'd0);
    frame(8, 0, "R1 R2 R6 mode0 lsb packed", 1'b1);
    cfg(2'd1, 1'b1, 1'b1, 4'd2);
    frame(5, 0, "R1 R2 R3 R7 mode1 msb bytes", 1'b1);
    cfg(2'd2, 1'b0, 1'b0, 4'd15);
    frame(17, 0, "R4 R1 mode2 drop15", 1'b1);
    cfg(2'd3, 1'b1, 1'b0, 4'd1);
    frame(6, 3, "R9 R8 mode3 stray bits", 1'b1);
    frame(2, 0, "R9 next frame clean", 1'b1);
    cfg(2'd0, 1'b1, 1'b1, 4'd3);
    frame(4, 0, "R5 reload frame A", 1'b1);
    frame(4, 0, "R5 reload frame B", 1'b1);
    cfg(2'd2, 1'b1, 1'b0, 4'd5);
    frame(3, 0, "R3 frame shorter than drop", 1'b1);
    cfg(2'd1, 1'b0, 1'b0, 4'd0);
    frame(4, 0, "R6 exact word no partial", 1'b1);
    frame(7, 0, "R8 three lanes", 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule